// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block is the purely combinational datapath of an 8-bit accumulator processor. Each evaluation takes an operation code, the accumulator, both index registers, an operand byte and the current status flags. It returns a result byte, a code naming the register that should capture that byte, and the updated negative, overflow, zero and carry flags. Instruction decode, the register file and memory access sit outside the block.

The operations are load, add with carry, subtract with borrow, compare against any of the three registers, AND, OR, XOR, bit test, the two shifts, the two rotates, increment, decrement, and a combined AND-then-subtract that lands in the X register. The flag rules depend on the operation. Flags that an operation does not define leave the block exactly as they entered. When the valid input is low, or the code is unassigned, the block is idle: every flag passes through and nothing is written.

Top module: `byte_alu`

## Requirements
- R1: Code 1 (add) returns acc + operand + C. C becomes bit 8 of the 9-bit sum. V is set when acc and operand share a sign and the result sign differs from acc. Dest is 1 (accumulator). Flags are packed as N=bit3, V=bit2, Z=bit1, C=bit0.
- R2: Code 2 (subtract) returns acc − operand − (1 − C). C is set when no borrow occurred. V is set when acc and operand differ in sign and the result sign differs from acc. Dest is 1.
- R3: Codes 3, 4 and 5 compare acc, X or Y with the operand. C is set when the register is greater than or equal to the operand. N and Z come from the low byte of the difference, which is also the result. V is unchanged. Dest is 0 (nothing written).
- R4: Code 16 returns (acc AND X) − operand. Its flags follow the compare rules. Dest is 2 (X register).
- R5: Code 9 (bit test) sets Z when (acc AND operand) is zero and copies operand bits 7 and 6 into N and V. C is unchanged, the result is acc AND operand, and dest is 0.
- R6: Codes 6, 7 and 8 return AND, OR and XOR of acc and operand, with N and Z from the result. V and C are unchanged. Dest is 1.
- R7: Code 10 shifts the operand left and moves bit 7 into C. Code 11 shifts it right, moves bit 0 into C and always clears N. Dest is 3 (operand's home location).
- R8: Code 12 rotates left, taking the old C into bit 0 and bit 7 into C. Code 13 rotates right, taking the old C into bit 7 and bit 0 into C. Dest is 3.
- R9: Codes 14 and 15 increment and decrement the operand modulo 256, with N and Z from the result. V and C are unchanged. Dest is 3.
- R10: Code 0 (load) returns the operand with N and Z from it. V and C are unchanged. Dest is 1.
- R11: With valid low, or with codes 17 to 31, the result is 0, dest is 0 and flags_out equals flags_in.
- R12: N is always result bit 7 and Z is always (result == 0) for every operation except bit test and the idle case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_valid | input | 1 | Operation present; low makes the unit idle |
| op | input | 5 | Operation code (see requirements) |
| acc | input | 8 | Accumulator value |
| xreg | input | 8 | X index register value |
| yreg | input | 8 | Y index register value |
| operand | input | 8 | Operand byte (memory or immediate) |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| result | output | 8 | Computed byte |
| dest | output | 2 | 0 none, 1 accumulator, 2 X register, 3 operand location |
| flags_out | output | 4 | Updated flags {N,V,Z,C} |

## Verification
Add and subtract are swept over every operand pair with both carry-in values. A wrong overflow term would flag sign changes that cannot happen, and an inverted borrow would make subtract off by one and flip its carry. Every other code sees all operand pairs with carry and overflow inputs that vary, so the bench notices a compare or logic operation that disturbs V, a logical right shift that leaves N set, a rotate that drops the incoming carry, and a bit test that derives N from the result instead of the operand. Unassigned codes and a low valid are checked for pure flag passthrough and no destination.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
   localparam int OP_W  = 5;
   localparam int DST_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_LOAD = 5'd0,  OP_ADD  = 5'd1,  OP_SUB  = 5'd2,  OP_CMPA = 5'd3,
      OP_CMPX = 5'd4,  OP_CMPY = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
      OP_XOR  = 5'd8,  OP_BIT  = 5'd9,  OP_ASL  = 5'd10, OP_LSR  = 5'd11,
      OP_ROL  = 5'd12, OP_ROR  = 5'd13, OP_INC  = 5'd14, OP_DEC  = 5'd15,
      OP_AXS  = 5'd16
   } alu_op_e;

   typedef enum logic [DST_W-1:0] {
      DST_NONE = 2'd0, DST_ACC = 2'd1, DST_XREG = 2'd2, DST_OPND = 2'd3
   } alu_dst_e;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } alu_flags_t;

   typedef enum logic [1:0] {
      AR_ADD = 2'd0, AR_SUB = 2'd1, AR_CMP = 2'd2
   } arith_mode_e;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
   import byte_alu_pkg::*;
#(
   parameter int W            = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  arith_mode_e    mode,
   input  logic [W-1:0]   lhs,
   input  logic [W-1:0]   rhs,
   input  logic           cin,
   output logic [W-1:0]   res,
   output logic           cout,
   output logic           ovf
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("byte_alu_arith: W must be at least 2");
      end

      if (SHARED_ADDER) begin : g_shared
         // One carry chain; subtraction by ones-complement of rhs.
         logic [W-1:0] rhs_eff;
         logic         cin_eff;
         logic [W:0]   sum;
         always_comb begin
            rhs_eff = (mode == AR_ADD) ? rhs : ~rhs;
            cin_eff = (mode == AR_CMP) ? 1'b1 : cin;
            sum     = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin_eff};
            res     = sum[MSB:0];
            cout    = sum[W];
            ovf     = ~(lhs[MSB] ^ rhs_eff[MSB]) & (lhs[MSB] ^ sum[MSB]);
         end
      end else begin : g_split
         // Separate adder and subtractor, selected at the output.
         logic [W:0] sum;
         logic [W:0] diff;
         logic       borrow_in;
         always_comb begin
            borrow_in = (mode == AR_SUB) ? ~cin : 1'b0;
            sum  = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
            diff = {1'b0, lhs} - {1'b0, rhs} - {{W{1'b0}}, borrow_in};
            if (mode == AR_ADD) begin
               res  = sum[MSB:0];
               cout = sum[W];
               ovf  = ~(lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ sum[MSB]);
            end else begin
               res  = diff[MSB:0];
               cout = ~diff[W];
               ovf  = (lhs[MSB] ^ rhs[MSB]) & (lhs[MSB] ^ diff[MSB]);
            end
         end
      end
   endgenerate

   always_comb begin
      if (!$isunknown({mode, lhs, rhs, cin})) begin
         if (mode == AR_CMP)
            assert_cmp_carry_R3: assert (cout == (lhs >= rhs))
               else $error("compare carry disagrees with magnitude");
         if (mode == AR_ADD)
            assert_add_total_R1: assert ({cout, res} ==
                  ({1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin}))
               else $error("add result is not the true sum");
      end
   end
endmodule

// File: rtl/byte_alu_unary.sv
module byte_alu_unary
   import byte_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   val,
   input  logic           cin,
   output logic [W-1:0]   res,
   output logic           cout
);
   localparam int MSB = W - 1;

   always_comb begin
      res  = val;
      cout = cin;
      unique case (op)
         OP_ASL: begin res = {val[MSB-1:0], 1'b0}; cout = val[MSB]; end
         OP_LSR: begin res = {1'b0, val[MSB:1]};   cout = val[0];   end
         OP_ROL: begin res = {val[MSB-1:0], cin};  cout = val[MSB]; end
         OP_ROR: begin res = {cin, val[MSB:1]};    cout = val[0];   end
         OP_INC: res = val + {{(W-1){1'b0}}, 1'b1};
         OP_DEC: res = val - {{(W-1){1'b0}}, 1'b1};
         default: ;
      endcase
   end

   always_comb begin
      if (!$isunknown({op, val, cin})) begin
         if (op == OP_LSR)
            assert_lsr_clear_top_R7: assert (res[MSB] == 1'b0)
               else $error("right shift left the top bit set");
         if (op == OP_ROR)
            assert_ror_carry_in_R8: assert (res[MSB] == cin && cout == val[0])
               else $error("right rotate lost the carry");
      end
   end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
   import byte_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   res
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_comb begin
            unique case (op)
               OP_OR:   res[i] = a[i] | b[i];
               OP_XOR:  res[i] = a[i] ^ b[i];
               default: res[i] = a[i] & b[i];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/byte_alu.sv
module byte_alu
   import byte_alu_pkg::*;
#(
   parameter int W            = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              op_valid,
   input  logic [4:0]        op,
   input  logic [W-1:0]      acc,
   input  logic [W-1:0]      xreg,
   input  logic [W-1:0]      yreg,
   input  logic [W-1:0]      operand,
   input  logic [3:0]        flags_in,
   output logic [W-1:0]      result,
   output logic [1:0]        dest,
   output logic [3:0]        flags_out
);
   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("byte_alu: W must be at least 2");
      end
   endgenerate

   alu_op_e     op_e;
   alu_flags_t  fin;
   alu_flags_t  fout;
   arith_mode_e ar_mode;
   logic [W-1:0] ar_lhs, ar_res, un_res, lg_res;
   logic         ar_c, ar_v, un_c;

   assign op_e = alu_op_e'(op);
   assign fin  = alu_flags_t'(flags_in);

   always_comb begin
      unique case (op_e)
         OP_SUB:                              ar_mode = AR_SUB;
         OP_CMPA, OP_CMPX, OP_CMPY, OP_AXS:   ar_mode = AR_CMP;
         default:                             ar_mode = AR_ADD;
      endcase
      unique case (op_e)
         OP_CMPX: ar_lhs = xreg;
         OP_CMPY: ar_lhs = yreg;
         OP_AXS:  ar_lhs = acc & xreg;
         default: ar_lhs = acc;
      endcase
   end

   byte_alu_arith #(.W(W), .SHARED_ADDER(SHARED_ADDER)) u_arith (
      .mode (ar_mode),
      .lhs  (ar_lhs),
      .rhs  (operand),
      .cin  (fin.c),
      .res  (ar_res),
      .cout (ar_c),
      .ovf  (ar_v)
   );

   byte_alu_unary #(.W(W)) u_unary (
      .op   (op_e),
      .val  (operand),
      .cin  (fin.c),
      .res  (un_res),
      .cout (un_c)
   );

   byte_alu_logic #(.W(W)) u_logic (
      .op   (op_e),
      .a    (acc),
      .b    (operand),
      .res  (lg_res)
   );

   always_comb begin
      logic set_nz;
      logic [1:0] d;
      logic [W-1:0] r;
      fout   = fin;
      r      = '0;
      d      = DST_NONE;
      set_nz = 1'b0;
      if (op_valid) begin
         unique case (op_e)
            OP_LOAD: begin r = operand; d = DST_ACC; set_nz = 1'b1; end
            OP_ADD, OP_SUB: begin
               r = ar_res; fout.c = ar_c; fout.v = ar_v;
               d = DST_ACC; set_nz = 1'b1;
            end
            OP_CMPA, OP_CMPX, OP_CMPY: begin
               r = ar_res; fout.c = ar_c; set_nz = 1'b1;
            end
            OP_AXS: begin
               r = ar_res; fout.c = ar_c; d = DST_XREG; set_nz = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
               r = lg_res; d = DST_ACC; set_nz = 1'b1;
            end
            OP_BIT: begin
               r = lg_res;
               fout.z = (lg_res == '0);
               fout.n = operand[MSB];
               fout.v = operand[MSB-1];
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
               r = un_res; fout.c = un_c; d = DST_OPND; set_nz = 1'b1;
            end
            OP_INC, OP_DEC: begin
               r = un_res; d = DST_OPND; set_nz = 1'b1;
            end
            default: ;
         endcase
      end
      if (set_nz) begin
         fout.n = r[MSB];
         fout.z = (r == '0);
      end
      result    = r;
      dest      = d;
      flags_out = fout;
   end

   always_comb begin
      if (!$isunknown({op_valid, op, acc, xreg, yreg, operand, flags_in})) begin
         if (!op_valid)
            assert_idle_passthru_R11: assert (dest == 2'd0 && flags_out == flags_in)
               else $error("idle unit changed flags or wrote a register");
         if (op_valid && op_e == OP_BIT)
            assert_bit_copy_R5: assert (flags_out[3] == operand[MSB] &&
                                        flags_out[2] == operand[MSB-1] &&
                                        flags_out[0] == flags_in[0])
               else $error("bit test flags not taken from operand");
         if (op_valid && (op_e == OP_CMPA || op_e == OP_CMPX || op_e == OP_CMPY))
            assert_cmp_keeps_v_R3: assert (flags_out[2] == flags_in[2] && dest == 2'd0)
               else $error("compare touched V or wrote a register");
      end
   end
endmodule

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;
   logic       clk = 1'b0;
   always #10 clk = ~clk;

   logic       op_valid;
   logic [4:0] op;
   logic [7:0] acc, xreg, yreg, operand;
   logic [3:0] flags_in;
   logic [7:0] result;
   logic [1:0] dest;
   logic [3:0] flags_out;

   byte_alu u0 (
      .op_valid (op_valid), .op (op), .acc (acc), .xreg (xreg), .yreg (yreg),
      .operand (operand), .flags_in (flags_in),
      .result (result), .dest (dest), .flags_out (flags_out)
   );

   typedef struct { logic [13:0] exp; string tag; } item_t;
   item_t q[$];
   event  applied;
   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;

   function automatic string tag_of(int code, bit valid);
      if (!valid || code > 16) return "R11";
      case (code)
         0: return "R10"; 1: return "R1"; 2: return "R2";
         3, 4, 5: return "R3"; 16: return "R4"; 9: return "R5";
         6, 7, 8: return "R6"; 10, 11: return "R7"; 12, 13: return "R8";
         default: return "R9";
      endcase
   endfunction

   // Independent reference: {result[7:0], dest[1:0], N, V, Z, C}
   function automatic logic [13:0] model(int code, int a, int x, int y, int m,
                                         logic [3:0] f, bit valid);
      int n = f[3], v = f[2], z = f[1], c = f[0];
      int r = 0, d = 0, s, lhs;
      bit nz = 0;
      if (valid) begin
         case (code)
            0: begin r = m; d = 1; nz = 1; end
            1: begin
               s = a + m + c; r = s % 256; c = (s > 255);
               v = ((a < 128) == (m < 128)) && ((r < 128) != (a < 128));
               d = 1; nz = 1;
            end
            2: begin
               s = a - m - (1 - c); r = (s + 512) % 256; c = (s >= 0);
               v = ((a < 128) != (m < 128)) && ((r < 128) != (a < 128));
               d = 1; nz = 1;
            end
            3, 4, 5, 16: begin
               lhs = (code == 3) ? a : (code == 4) ? x : (code == 5) ? y : (a & x);
               r = (lhs - m + 256) % 256; c = (lhs >= m); nz = 1;
               d = (code == 16) ? 2 : 0;
            end
            6: begin r = a & m; d = 1; nz = 1; end
            7: begin r = a | m; d = 1; nz = 1; end
            8: begin r = a ^ m; d = 1; nz = 1; end
            9: begin r = a & m; z = (r == 0); n = (m >> 7) & 1; v = (m >> 6) & 1; end
            10: begin r = (m * 2) % 256; c = m / 128; d = 3; nz = 1; end
            11: begin r = m / 2; c = m % 2; d = 3; nz = 1; end
            12: begin r = (m * 2) % 256 + c; c = m / 128; d = 3; nz = 1; end
            13: begin r = m / 2 + c * 128; c = m % 2; d = 3; nz = 1; end
            14: begin r = (m + 1) % 256; d = 3; nz = 1; end
            15: begin r = (m + 255) % 256; d = 3; nz = 1; end
            default: ;
         endcase
      end
      if (nz) begin n = (r >= 128); z = (r == 0); end   // R12
      return {r[7:0], d[1:0], n[0], v[0], z[0], c[0]};
   endfunction

   task automatic drive(bit valid, int code, int a, int x, int y, int m, logic [3:0] f);
      item_t it;
      op_valid = valid; op = code[4:0]; acc = a[7:0]; xreg = x[7:0];
      yreg = y[7:0]; operand = m[7:0]; flags_in = f;
      it.exp = model(code, a, x, y, m, f, valid);
      it.tag = tag_of(code, valid);
      q.push_back(it);
      -> applied;
      #1;
   endtask

   // Monitor: pops the expected item and compares mid-window
   initial begin
      item_t it;
      logic [13:0] act;
      forever begin
         @(applied);
         #0.5;
         it  = q.pop_front();
         act = {result, dest, flags_out};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: op=%0d acc=%02h x=%02h y=%02h m=%02h f=%h got res=%02h dst=%0d fl=%h exp res=%02h dst=%0d fl=%h",
                     it.tag, op, acc, xreg, yreg, operand, flags_in,
                     act[13:6], act[5:4], act[3:0], it.exp[13:6], it.exp[5:4], it.exp[3:0]);
         end
      end
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // Idle state after start (R11): valid low, flags pass through
      for (int k = 0; k < 16; k++) drive(1'b0, k, 8'hA5, 8'h3C, 8'hC3, 8'hFF, k[3:0]);
      // R11: unassigned codes
      for (int code = 17; code < 32; code++)
         for (int k = 0; k < 16; k++) drive(1'b1, code, k * 17, 0, 0, 255 - k, k[3:0]);
      // R1, R2: exhaustive with both carry-in values, V in varies
      for (int code = 1; code <= 2; code++)
         for (int cy = 0; cy < 2; cy++)
            for (int a = 0; a < 256; a++)
               for (int m = 0; m < 256; m++)
                  drive(1'b1, code, a, 0, 0, m, {a[0], m[1], a[2] ^ m[0], cy[0]});
      // R3..R10, R12: every operand pair, X/Y and incoming flags varied
      for (int code = 0; code <= 16; code++) begin
         if (code == 1 || code == 2) continue;
         for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m++)
               drive(1'b1, code, a, (a * 7 + m) % 256, (m * 3 + 1) % 256, m,
                     {m[2], a[1] ^ m[3], a[5], a[0] ^ m[0]});
      end
      // Boundary picks: add overflow 7F+01, subtract borrow 00-01, compare equal
      drive(1'b1, 1, 8'h7F, 0, 0, 8'h01, 4'b0000);  // R1
      drive(1'b1, 2, 8'h00, 0, 0, 8'h01, 4'b0001);  // R2
      drive(1'b1, 4, 0, 8'h40, 0, 8'h40, 4'b0100);  // R3
      drive(1'b1, 16, 8'hF0, 8'h3C, 0, 8'h30, 4'b0000); // R4
      #5;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule